// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is an 8-bit arithmetic and logic unit built around a working accumulator. Each operation takes the accumulator and a file operand supplied from outside, and it computes an add, a subtract, a bitwise AND, OR or XOR, or a move of the operand. A destination select bit decides where the result goes. Either it loads the accumulator, or it is registered on a write-back port so that surrounding logic can store it back to the operand's location. The accumulator is not part of any addressable space and has no address.

Alongside the accumulator the block keeps an 8-bit status word with five live flags: carry, nibble digit-carry, zero, signed overflow and negative. The arithmetic operations update all five flags. The logic operations and the move update only zero and negative. The accumulator, the status word and the write-back outputs all change on the clock edge at which a valid operation is presented. Instruction decode, the memory write itself and branch evaluation sit outside the block.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, and after it is released, acc_q, status_q and wb_valid all read 0 until the first valid operation.
- R2: Opcode 3'b000 is ADD, with result = acc + file_in mod 256. Carry (status bit 0) is set when the sum carries out of bit 7. Digit-carry (status bit 1) is set when the low nibbles carry into bit 4.
- R3: Opcode 3'b001 is SUB, with result = file_in - acc mod 256. Carry (bit 0) is set when a borrow occurs (file_in < acc). Digit-carry (bit 1) is set when the low nibble borrows (file_in[3:0] < acc[3:0]).
- R4: Overflow (status bit 3) is set when a signed overflow occurs. For ADD this means both operands have the same sign and the result's sign differs. For SUB it means the operands' signs differ and the result's sign differs from file_in's sign.
- R5: For every defined opcode, zero (status bit 2) is 1 exactly when the 8-bit result is 0, and negative (status bit 4) equals bit 7 of the result.
- R6: Opcodes 3'b010 AND, 3'b011 OR and 3'b100 XOR combine acc with file_in bitwise. Opcode 3'b101 MOV passes file_in through. These four leave carry, digit-carry and overflow unchanged.
- R7: When dest_acc is 1, the result loads acc_q. When dest_acc is 0, acc_q keeps its value, the result appears on wb_data and wb_valid is 1 for the one cycle after the operation's edge.
- R8: When op_valid is low, acc_q and status_q hold their values and wb_valid is 0 in the next cycle.
- R9: Opcodes 3'b110 and 3'b111 are undefined. They change neither acc_q nor status_q, and they do not raise wb_valid.
- R10: Status bits 7 to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Perform the operation on this edge |
| op_code | input | 3 | Operation select |
| dest_acc | input | 1 | 1: result to accumulator, 0: result to write-back |
| file_in | input | 8 | File operand |
| acc_q | output | 8 | Accumulator contents |
| status_q | output | 8 | Status word {3'b0, N, OV, Z, DC, C} |
| wb_data | output | 8 | Registered write-back result |
| wb_valid | output | 1 | Write-back result is valid this cycle |

## Verification
The embedded properties assume that op_code, dest_acc and file_in are known whenever op_valid is high. They also assume that reset is held for at least one rising edge, so that every register starts from a defined value. The stimulus changes inputs only on falling edges and never leaves them unknown. Each cycle draws a fresh operand, opcode, destination and valid bit, so idle cycles, undefined opcodes and both destinations all appear between the directed cases. The directed cases cover carry, borrow, nibble carry and signed overflow at their exact boundaries.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic         dest_acc,
  input  logic [W-1:0] file_in,
  output logic [W-1:0] acc_q,
  output logic [7:0]   status_q,
  output logic [W-1:0] wb_data,
  output logic         wb_valid
);
  localparam int NIB = W / 2;
  localparam int B_C = 0, B_DC = 1, B_Z = 2, B_OV = 3, B_N = 4;

  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2,
                         OP_OR  = 3'd3, OP_XOR = 3'd4, OP_MOV = 3'd5;

  logic [W:0]     sum_w, dif_w;
  logic [NIB:0]   nsum_w, ndif_w;
  logic [W-1:0]   res;
  logic           arith, known, c_n, dc_n, ov_n;
  logic [4:0]     flags_n;

  assign sum_w  = {1'b0, acc_q} + {1'b0, file_in};
  assign dif_w  = {1'b0, file_in} - {1'b0, acc_q};
  assign nsum_w = {1'b0, acc_q[NIB-1:0]} + {1'b0, file_in[NIB-1:0]};
  assign ndif_w = {1'b0, file_in[NIB-1:0]} - {1'b0, acc_q[NIB-1:0]};

  assign arith = (op_code == OP_ADD) || (op_code == OP_SUB);
  assign known = op_code <= OP_MOV;

  always_comb begin
    res  = file_in;
    c_n  = status_q[B_C];
    dc_n = status_q[B_DC];
    ov_n = status_q[B_OV];
    case (op_code)
      OP_ADD: begin
        res  = sum_w[W-1:0];
        c_n  = sum_w[W];
        dc_n = nsum_w[NIB];
        ov_n = (acc_q[W-1] == file_in[W-1]) && (res[W-1] != acc_q[W-1]);
      end
      OP_SUB: begin
        res  = dif_w[W-1:0];
        c_n  = dif_w[W];
        dc_n = ndif_w[NIB];
        ov_n = (acc_q[W-1] != file_in[W-1]) && (res[W-1] != file_in[W-1]);
      end
      OP_AND:  res = acc_q & file_in;
      OP_OR:   res = acc_q | file_in;
      OP_XOR:  res = acc_q ^ file_in;
      default: res = file_in;
    endcase
  end

  assign flags_n = {res[W-1], ov_n, (res == '0), dc_n, c_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      status_q <= '0;
      wb_data  <= '0;
      wb_valid <= 1'b0;
    end else begin
      wb_valid <= op_valid && known && !dest_acc;
      if (op_valid && known) begin
        status_q <= {3'b000, flags_n};
        if (dest_acc) acc_q   <= res;
        else          wb_data <= res;
      end
    end
  end

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[7:5] == 3'b000);

  assert_logic_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && known && !arith) |=>
      ($stable(status_q[B_C]) && $stable(status_q[B_DC]) && $stable(status_q[B_OV])));

  assert_zero_tracks_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && known && dest_acc) |=> (status_q[B_Z] == (acc_q == '0)));

  assert_neg_tracks_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && known && dest_acc) |=> (status_q[B_N] == acc_q[W-1]));

  assert_file_dest_keeps_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dest_acc) |=> ($stable(acc_q) && (wb_valid == $past(known))));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || !known) |=> ($stable(acc_q) && $stable(status_q) && !wb_valid));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic       dest_acc = 1'b0;
  logic [7:0] file_in = 8'd0;
  logic [7:0] acc_q, status_q, wb_data;
  logic       wb_valid;

  int tests = 0, fails = 0;
  int m_acc = 0, m_c = 0, m_dc = 0, m_z = 0, m_ov = 0, m_n = 0, m_wb = 0, m_wbv = 0;
  bit done = 0;

  always #2 clk = ~clk;

  acc_alu u_dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
                 .dest_acc(dest_acc), .file_in(file_in), .acc_q(acc_q),
                 .status_q(status_q), .wb_data(wb_data), .wb_valid(wb_valid));

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int op, input bit d, input int f);
    int r, a, fl, cc, dd, oo;
    string tag;
    op_valid = v; op_code = op[2:0]; dest_acc = d; file_in = f[7:0];
    a = m_acc; fl = f & 255;
    cc = m_c; dd = m_dc; oo = m_ov; r = fl;
    m_wbv = 0;
    if (!v) tag = "R8";
    else if (op > 5) tag = "R9";
    else if (op == 0) tag = "R2";
    else if (op == 1) tag = "R3";
    else tag = "R6";
    if (v && op <= 5) begin
      case (op)
        0: begin
          r = (a + fl) & 255; cc = (a + fl) > 255; dd = ((a & 15) + (fl & 15)) > 15;
          oo = ((a >= 128) == (fl >= 128)) && ((r >= 128) != (a >= 128));
        end
        1: begin
          r = (fl - a) & 255; cc = fl < a; dd = (fl & 15) < (a & 15);
          oo = ((a >= 128) != (fl >= 128)) && ((r >= 128) != (fl >= 128));
        end
        2: r = a & fl;
        3: r = a | fl;
        4: r = a ^ fl;
        default: r = fl;
      endcase
      m_c = cc; m_dc = dd; m_ov = oo; m_z = (r == 0); m_n = (r >= 128);
      if (d) m_acc = r;
      else begin m_wb = r; m_wbv = 1; end
    end
    @(negedge clk);
    check(d || !v || op > 5 ? tag : "R7", "acc", int'(acc_q), m_acc);
    check(tag, "carry", int'(status_q[0]), m_c);
    check(tag, "digit carry", int'(status_q[1]), m_dc);
    check((op <= 1 && v) ? "R4" : tag, "overflow", int'(status_q[3]), m_ov);
    check("R5", "zero", int'(status_q[2]), m_z);
    check("R5", "negative", int'(status_q[4]), m_n);
    check("R10", "unused bits", int'(status_q[7:5]), 0);
    check(tag == "R8" || tag == "R9" ? tag : "R7", "wb_valid", int'(wb_valid), m_wbv);
    if (m_wbv) check("R7", "wb_data", int'(wb_data), m_wb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "acc", int'(acc_q), 0);
    check("R1", "status", int'(status_q), 0);
    check("R1", "wb_valid", int'(wb_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "acc after release", int'(acc_q), 0);
    check("R1", "status after release", int'(status_q), 0);
    // directed corners
    step(1, 5, 1, 8'h0F);   // MOV into acc
    step(1, 0, 1, 8'h01);   // R2 nibble carry 0F+01
    step(1, 0, 1, 8'hF0);   // R2 carry out 10+F0 -> 00
    step(1, 5, 1, 8'h7F);
    step(1, 0, 1, 8'h01);   // R4 7F+01 overflow
    step(1, 5, 1, 8'h80);
    step(1, 0, 0, 8'h80);   // R4 80+80 to file
    step(1, 1, 1, 8'h00);   // R3 borrow 00-80, overflow
    step(1, 5, 1, 8'h01);
    step(1, 1, 0, 8'h01);   // R3 equal -> zero, no borrow
    step(1, 1, 0, 8'h10);   // R3 nibble borrow 10-01
    step(1, 2, 1, 8'h00);   // R6 AND -> zero, flags C/DC/OV kept
    step(1, 3, 1, 8'h80);   // R6 OR
    step(1, 4, 0, 8'hFF);   // R6 XOR to file
    step(0, 0, 1, 8'h55);   // R8 idle
    step(1, 6, 1, 8'h12);   // R9 undefined
    step(1, 7, 0, 8'h34);   // R9 undefined
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, int'($urandom % 8), 1'($urandom % 2), int'($urandom % 256));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule